// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed RISC-V instruction into the 32-bit base-ISA instruction that does the same work. It is pure combinational logic: a word on the input gives its expansion on the output within the same cycle. There is no clock and no state. It is meant to sit in a fetch path directly after instruction alignment.

It covers a subset of the compressed encodings:
- the register-register ALU group: add, sub, xor, or, and, and the register move;
- the immediate add and the immediate and;
- the three shift-immediate forms;
- the breakpoint.

Two-operand compressed forms are rebuilt as three-operand instructions, with the destination register reused as the first source. Every encoding outside this subset gives an all-zero output and raises a separate illegal flag. The rest of the pipeline can then trap on it.

Top module: `cexp_expander`

## Requirements
- R1: A 3-bit compact register field with value n, taken from bits [9:7] (destination) or [4:2] (second source), selects register x(8+n). The immediate and, the right shifts, and the sub/xor/or/and group use compact fields.
- R2: With quadrant 01 (bits [1:0]), funct3 100 (bits [15:13]), bit 12 clear and bits [11:10] equal to 11, bits [6:5] pick sub (00), xor (01), or (10) or and (11). The expansion is an OP instruction with rd as destination and first source and rs2 as second source. funct3 values are 000, 100, 110 and 111 respectively. A register add (quadrant 10, funct3 100, bit 12 set, rs2 in [6:2] non-zero) uses the full 5-bit fields [11:7] and [6:2] and expands the same way with funct3 000.
- R3: With quadrant 10, funct3 100, bit 12 clear and a non-zero field [6:2], the word is a register move. It expands to add rd, x0, rs2, with rd taken from [11:7].
- R4: The 6-bit immediate is bit 12 (sign) followed by bits [6:2], sign-extended to 12 bits. The immediate add (quadrant 01, funct3 000, full rd in [11:7]) expands to addi with funct3 000. The immediate and (quadrant 01, funct3 100, [11:10]=10) expands to andi with funct3 111.
- R5: The shift amount is bit 12 followed by bits [6:2]. The shifts are srli ([11:10]=00) and srai ([11:10]=01) in quadrant 01 funct3 100, and slli (quadrant 10, funct3 000, full rd). They expand to OP-IMM with funct3 101, 101 and 001. With 32-bit registers, a zero shift amount or a set bit 12 is illegal.
- R6: The word 0x9002 expands to 0x00100073.
- R7: Any other encoding gives output 0 with the illegal flag set. This includes quadrant 11, all of quadrant 00 (the all-zero word among them), the jump-register patterns, and the register group with bit 12 set. A supported word clears the flag.
- R8: The output opcode is 0110011 for register ops, 0010011 for immediate ops and 1110011 for the breakpoint. funct7 is 0100000 for sub and srai and 0000000 otherwise.
- R9: The output follows a change of the input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Compressed instruction word |
| instr_o | output | 32 | Expanded 32-bit instruction, zero when illegal |
| illegal_o | output | 1 | High when the input is outside the supported set |

## Verification
The shift decode and the illegal-pattern detection act on the same word. A shift word with bit 12 set, or with a zero amount, sits in the exact field pattern of a legal shift, so both functions decide on it at once. The same holds for the register group with bit 12 set, and for the move and add encodings whose second source field is zero. The sweep over all 65536 inputs reaches every one of these collisions. Each result is judged against an independent pattern model, which demands both a zero word and a raised flag.

// File: rtl/cexp_pkg.sv
package cexp_pkg;

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;
  localparam logic [2:0] F3_ADD  = 3'b000;
  localparam logic [2:0] F3_SLL  = 3'b001;
  localparam logic [2:0] F3_XOR  = 3'b100;
  localparam logic [2:0] F3_SR   = 3'b101;
  localparam logic [2:0] F3_OR   = 3'b110;
  localparam logic [2:0] F3_AND  = 3'b111;
  localparam logic [31:0] BRK_WORD = 32'h0010_0073;

  typedef enum logic [3:0] {
    COP_ILL, COP_ADD, COP_SUB, COP_XOR, COP_OR, COP_AND, COP_MV,
    COP_ADDI, COP_ANDI, COP_SLLI, COP_SRLI, COP_SRAI, COP_BRK
  } cop_e;

  typedef struct packed {
    logic [4:0] rd_wide;
    logic [4:0] rs2_wide;
    logic [4:0] rd_short;
    logic [4:0] rs2_short;
    logic [5:0] imm6;
  } cfields_t;

  function automatic logic [31:0] pack_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                         logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_REG};
  endfunction

  function automatic logic [31:0] pack_i(logic [11:0] imm, logic [4:0] rs1,
                                         logic [2:0] f3, logic [4:0] rd);
    return {imm, rs1, f3, rd, OPC_IMM};
  endfunction

endpackage

// File: rtl/cexp_fields.sv
module cexp_fields
  import cexp_pkg::*;
#(
  parameter int CREG_BASE = 8
) (
  input  logic [12:2] bits_i,
  output cfields_t    fields_o
);
  always_comb begin
    fields_o.rd_wide   = bits_i[11:7];
    fields_o.rs2_wide  = bits_i[6:2];
    fields_o.rd_short  = 5'(CREG_BASE) + {2'b00, bits_i[9:7]};
    fields_o.rs2_short = 5'(CREG_BASE) + {2'b00, bits_i[4:2]};
    fields_o.imm6      = {bits_i[12], bits_i[6:2]};
  end
endmodule

// File: rtl/cexp_classify.sv
module cexp_classify
  import cexp_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [15:0] instr_i,
  output cop_e        op_o
);
  logic       shamt_ok;
  logic [1:0] quad;
  logic [2:0] major;
  logic       rs2_nz;
  logic       rd_nz;

  assign quad   = instr_i[1:0];
  assign major  = instr_i[15:13];
  assign rs2_nz = |instr_i[6:2];
  assign rd_nz  = |instr_i[11:7];

  generate
    if (XLEN == 32) begin : g_rv32_shamt
      assign shamt_ok = ~instr_i[12] & rs2_nz;
    end else begin : g_wide_shamt
      assign shamt_ok = instr_i[12] | rs2_nz;
    end
  endgenerate

  always_comb begin
    op_o = COP_ILL;
    unique case (quad)
      2'b01: begin
        if (major == 3'b000) op_o = COP_ADDI;
        else if (major == 3'b100) begin
          unique case (instr_i[11:10])
            2'b00: op_o = shamt_ok ? COP_SRLI : COP_ILL;
            2'b01: op_o = shamt_ok ? COP_SRAI : COP_ILL;
            2'b10: op_o = COP_ANDI;
            default: begin
              if (!instr_i[12]) begin
                unique case (instr_i[6:5])
                  2'b00:   op_o = COP_SUB;
                  2'b01:   op_o = COP_XOR;
                  2'b10:   op_o = COP_OR;
                  default: op_o = COP_AND;
                endcase
              end
            end
          endcase
        end
      end
      2'b10: begin
        if (major == 3'b000) op_o = shamt_ok ? COP_SLLI : COP_ILL;
        else if (major == 3'b100) begin
          if (!instr_i[12]) op_o = rs2_nz ? COP_MV : COP_ILL;
          else if (rs2_nz) op_o = COP_ADD;
          else if (!rd_nz) op_o = COP_BRK;
        end
      end
      default: op_o = COP_ILL;
    endcase
  end

  always_comb begin
    if (!$isunknown(instr_i)) begin
      // R7
      quad_ill_chk: assert (!(quad == 2'b11 || quad == 2'b00) || op_o == COP_ILL);
    end
  end
endmodule

// File: rtl/cexp_assemble.sv
module cexp_assemble
  import cexp_pkg::*;
(
  input  cop_e        op_i,
  input  cfields_t    fields_i,
  output logic [31:0] word_o
);
  logic [11:0] simm;
  logic [11:0] sh_base;
  logic [11:0] sh_alt;

  assign simm    = {{6{fields_i.imm6[5]}}, fields_i.imm6};
  assign sh_base = {F7_BASE, 5'b0} | {6'b0, fields_i.imm6};
  assign sh_alt  = {F7_ALT, 5'b0} | {6'b0, fields_i.imm6};

  always_comb begin
    word_o = '0;
    unique case (op_i)
      COP_ADD:  word_o = pack_r(F7_BASE, fields_i.rs2_wide, fields_i.rd_wide, F3_ADD, fields_i.rd_wide);
      COP_MV:   word_o = pack_r(F7_BASE, fields_i.rs2_wide, 5'd0, F3_ADD, fields_i.rd_wide);
      COP_SUB:  word_o = pack_r(F7_ALT, fields_i.rs2_short, fields_i.rd_short, F3_ADD, fields_i.rd_short);
      COP_XOR:  word_o = pack_r(F7_BASE, fields_i.rs2_short, fields_i.rd_short, F3_XOR, fields_i.rd_short);
      COP_OR:   word_o = pack_r(F7_BASE, fields_i.rs2_short, fields_i.rd_short, F3_OR, fields_i.rd_short);
      COP_AND:  word_o = pack_r(F7_BASE, fields_i.rs2_short, fields_i.rd_short, F3_AND, fields_i.rd_short);
      COP_ADDI: word_o = pack_i(simm, fields_i.rd_wide, F3_ADD, fields_i.rd_wide);
      COP_ANDI: word_o = pack_i(simm, fields_i.rd_short, F3_AND, fields_i.rd_short);
      COP_SLLI: word_o = pack_i(sh_base, fields_i.rd_wide, F3_SLL, fields_i.rd_wide);
      COP_SRLI: word_o = pack_i(sh_base, fields_i.rd_short, F3_SR, fields_i.rd_short);
      COP_SRAI: word_o = pack_i(sh_alt, fields_i.rd_short, F3_SR, fields_i.rd_short);
      COP_BRK:  word_o = BRK_WORD;
      default:  word_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(fields_i)) begin
      if (word_o[6:0] == OPC_REG && word_o[19:15] != 5'd0) begin
        // R2
        same_src_dst_chk: assert (word_o[19:15] == word_o[11:7]);
      end
      if (word_o[6:0] == OPC_REG) begin
        // R8
        funct7_chk: assert (word_o[31:25] == F7_BASE || word_o[31:25] == F7_ALT);
      end
      if (op_i == COP_SLLI || op_i == COP_SRLI || op_i == COP_SRAI) begin
        // R5
        shamt_nonzero_chk: assert (word_o[24:20] != 5'd0);
      end
    end
  end
endmodule

// File: rtl/cexp_expander.sv
module cexp_expander
  import cexp_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CREG_BASE = 8
) (
  input  logic [15:0] instr_i,
  output logic [31:0] instr_o,
  output logic        illegal_o
);
  cop_e     op;
  cfields_t fields;

  cexp_fields #(.CREG_BASE(CREG_BASE)) u_fields (
    .bits_i  (instr_i[12:2]),
    .fields_o(fields)
  );

  cexp_classify #(.XLEN(XLEN)) u_classify (
    .instr_i(instr_i),
    .op_o   (op)
  );

  cexp_assemble u_assemble (
    .op_i    (op),
    .fields_i(fields),
    .word_o  (instr_o)
  );

  assign illegal_o = (op == COP_ILL);

  always_comb begin
    if (!$isunknown(instr_i)) begin
      if (illegal_o) begin
        // R7
        illegal_zero_chk: assert (instr_o == 32'd0);
      end
      if (instr_i == 16'h9002) begin
        // R6
        brk_word_chk: assert (instr_o == BRK_WORD && !illegal_o);
      end
      if (!illegal_o && instr_i[1:0] == 2'b01 && instr_i[15:13] == 3'b100) begin
        // R1
        creg_range_chk: assert (instr_o[11:10] == 2'b01 && instr_o[19:15] == instr_o[11:7]);
      end
    end
  end
endmodule

// File: tb/cexp_expander_test.sv
module cexp_expander_test;
  logic        clk = 1'b0;
  logic [15:0] instr_i = 16'h0000;
  logic [31:0] instr_o;
  logic        illegal_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cexp_expander uut (
    .instr_i  (instr_i),
    .instr_o  (instr_o),
    .illegal_o(illegal_o)
  );

  function automatic logic [31:0] r_word(logic [6:0] f7, logic [4:0] s2, logic [4:0] s1,
                                         logic [2:0] f3, logic [4:0] d);
    return (32'(f7) << 25) | (32'(s2) << 20) | (32'(s1) << 15) | (32'(f3) << 12) |
           (32'(d) << 7) | 32'h33;
  endfunction

  function automatic logic [31:0] i_word(int imm, logic [4:0] s1, logic [2:0] f3, logic [4:0] d);
    return (32'(imm & 12'hfff) << 20) | (32'(s1) << 15) | (32'(f3) << 12) |
           (32'(d) << 7) | 32'h13;
  endfunction

  task automatic model(input logic [15:0] c, output logic [31:0] w, output logic ill,
                       output string tag);
    int sv;
    int sh;
    logic [4:0] rl, rc, sc, s2l;
    w = 32'd0; ill = 1'b1; tag = "R7";
    sv  = c[12] ? int'(c[6:2]) - 32 : int'(c[6:2]);
    sh  = int'(c[12]) * 32 + int'(c[6:2]);
    rl  = c[11:7];
    s2l = c[6:2];
    rc  = 5'(8 + int'(c[9:7]));
    sc  = 5'(8 + int'(c[4:2]));
    if (c[1:0] == 2'b01 && c[15:13] == 3'b000) begin
      w = i_word(sv, rl, 3'd0, rl); ill = 1'b0; tag = "R4";
    end else if (c[1:0] == 2'b01 && c[15:13] == 3'b100) begin
      if (c[11] == 1'b0) begin
        if (sh >= 1 && sh <= 31) begin
          w = i_word(sh + (c[10] ? 1024 : 0), rc, 3'd5, rc); ill = 1'b0; tag = "R5 R1 R8";
        end else tag = "R5 R7";
      end else if (c[10] == 1'b0) begin
        w = i_word(sv, rc, 3'd7, rc); ill = 1'b0; tag = "R4 R1";
      end else if (c[12] == 1'b0) begin
        ill = 1'b0; tag = "R2 R1 R8";
        case (c[6:5])
          2'd0: w = r_word(7'h20, sc, rc, 3'd0, rc);
          2'd1: w = r_word(7'h00, sc, rc, 3'd4, rc);
          2'd2: w = r_word(7'h00, sc, rc, 3'd6, rc);
          default: w = r_word(7'h00, sc, rc, 3'd7, rc);
        endcase
      end
    end else if (c[1:0] == 2'b10 && c[15:13] == 3'b000) begin
      if (sh >= 1 && sh <= 31) begin
        w = i_word(sh, rl, 3'd1, rl); ill = 1'b0; tag = "R5";
      end else tag = "R5 R7";
    end else if (c[1:0] == 2'b10 && c[15:13] == 3'b100) begin
      if (!c[12] && s2l != 0) begin
        w = r_word(7'h00, s2l, 5'd0, 3'd0, rl); ill = 1'b0; tag = "R3";
      end else if (c[12] && s2l != 0) begin
        w = r_word(7'h00, s2l, rl, 3'd0, rl); ill = 1'b0; tag = "R2";
      end else if (c[12] && rl == 0) begin
        w = 32'h0010_0073; ill = 1'b0; tag = "R6";
      end
    end
  endtask

  task automatic judge(input string tag, input logic [31:0] ew, input logic ei);
    checks++;
    if (instr_o !== ew || illegal_o !== ei) begin
      errors++;
      $display("FAIL %s in=%h got %h/%b exp %h/%b", tag, instr_i, instr_o, illegal_o, ew, ei);
    end
  endtask

  initial begin
    logic [31:0] ew;
    logic ei;
    string tag;
    #5;
    judge("R7 zero word", 32'd0, 1'b1);
    // Directed words: R9 output settles with no clock edge in between
    instr_i = 16'h9002; #1; judge("R6 R9", 32'h0010_0073, 1'b0);
    instr_i = 16'h8426; #1; judge("R3 R9", 32'h0090_0433, 1'b0);
    instr_i = 16'h8C05; #1; judge("R2 R8 R1", 32'h4094_0433, 1'b0);
    instr_i = 16'h987D; #1; judge("R4 R1", 32'hFFF4_7413, 1'b0);
    instr_i = 16'h0003; #1; judge("R7 quadrant 11", 32'd0, 1'b1);
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      instr_i = 16'(v);
      #2;
      model(instr_i, ew, ei, tag);
      judge(tag, ew, ei);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R9 got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule